// File: doc/BRIEF.md
# Serial Inversionless Error-Locator Solver

This block takes the 2t syndromes of a received word over GF(2^M) and computes the error-locator polynomial λ(x). It runs the inversionless Berlekamp-Massey recursion, which needs no field division. The correction strength t is chosen per request at run time, up to the synthesized maximum TMAX. The number of iterations is 2t, so a weaker code finishes sooner.

All field products pass through one shared GF(2^M) multiplier, one product per clock. This makes the block much smaller than a solver with a full multiplier array, and in exchange it is slower. A small scheduler runs each iteration in two phases. The discrepancy phase takes t+1 products. The update phase takes 2(t+1) products, and it rewrites λ(x) and the auxiliary polynomial b(x) in place, from the top coefficient down.

The syndromes arrive on a valid/ready input stream and the result leaves on a valid/ready output stream. The upstream stage may present a request at any time, and it is accepted only while the block is idle. The downstream stage may hold off the result for as long as it needs. While the result waits, it stays frozen on the outputs and no new request is accepted.

Top module: `locator_ibm_serial`

## Requirements
- R1: `in_ready` is high only while the block is idle. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` then stays low until the result has been taken. The syndromes are captured at acceptance, so later changes on `in_syn` have no effect on the request in flight.
- R2: Once `out_valid` rises, it stays high, and `out_lambda`, `out_degree` and `out_uncorrectable` stay stable until an edge with `out_ready` high. After that edge, `out_valid` is low and `in_ready` is high.
- R3: `out_lambda` holds λ_0 in bits [M-1:0] and λ_i in bits [(i+1)M-1:iM]. It is the result of 2t inversionless steps started from λ = b = 1 and γ = 1. In step r (0-based), δ = Σ_{i=0..t} λ_i·S_{r+1-i}, where S_j = 0 for j < 1. Then λ becomes γ·λ + δ·x·b. If δ ≠ 0 and 2L ≤ r, then b takes the old λ, L becomes r+1−L and γ becomes δ. Otherwise b becomes x·b. Both polynomials are kept modulo x^(t+1). The field uses a polynomial basis, with bit k holding the coefficient of α^k, and reduces by POLY. For at most t errors, λ vanishes at the inverse of every error location.
- R4: `out_degree` is the register L of the recursion. For at most t errors it equals the number of errors.
- R5: `out_uncorrectable` is high exactly when `out_degree` is greater than the effective t.
- R6: If at least one of S_1..S_2t is nonzero, `out_valid` rises exactly 6t(t+1) clock edges after the accepting edge. If all of them are zero, the iteration is skipped: `out_valid` is high right after the accepting edge, with λ = 1 and degree 0.
- R7: The effective t is `in_t`, except that 0 is treated as 1 and values above TMAX are treated as TMAX. The syndromes above S_2t have no effect on the result, and the coefficients above λ_t are output as zero. Syndrome S_j sits in bits [jM-1:(j-1)M] of `in_syn`.
- R8: The multiplier build chosen by MUL_ARCH (0 = shift-and-reduce, 1 = full product then reduce) gives identical outputs on every cycle.
- R9: After reset, `in_ready` is high and `out_valid` is low.
- R10: λ_0 and γ are never zero. When the result is correctable, every coefficient above `out_degree` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle, request can be accepted |
| in_t | input | $clog2(TMAX+1) | Requested correction strength |
| in_syn | input | 2·TMAX·M | Syndromes S_1..S_2TMAX, S_1 in the low bits |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_lambda | output | (TMAX+1)·M | Locator coefficients, λ_0 in the low bits |
| out_degree | output | $clog2(2·TMAX+1) | Locator degree L |
| out_uncorrectable | output | 1 | Degree exceeds the effective t |

## Verification
Some properties are checked by assertions on every cycle:
- the exact 6t(t+1)-cycle run length, counted by an independent counter;
- the immediate result on all-zero syndromes;
- `in_ready` closing once a request is accepted;
- the held, stable result under back-pressure;
- the invariants of the recursion: γ and λ_0 never zero, and nothing above the degree, or above t, left in the polynomial.

Whether the coefficients are the right ones can only be shown by the bench scenarios. The bench feeds syndromes of error patterns of weight 0 to t+1 and compares each result against a behavioural model of the recursion. It also checks that λ has a root at the inverse of every error location.

// File: rtl/locator_pkg.sv
package locator_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } ctl_state_t;

  // Which product the shared multiplier forms this cycle
  typedef enum logic [1:0] {
    OP_DISC  = 2'd0,  // lambda_i * S_(r+1-i), summed into delta
    OP_SCALE = 2'd1,  // gamma * lambda_i, parked in the accumulator
    OP_MERGE = 2'd2   // delta * b_(i-1), merged and written back
  } op_kind_t;

endpackage

// File: rtl/gf_mul.sv
module gf_mul #(
  parameter int unsigned  M    = 4,
  parameter logic [M:0]   POLY = 5'h13,
  parameter int unsigned  ARCH = 0
) (
  input  logic [M-1:0] a,
  input  logic [M-1:0] b,
  output logic [M-1:0] p
);

  generate
    if (ARCH == 0) begin : g_shift_reduce
      // MSB-first: reduce after each shift
      always_comb begin
        logic [M-1:0] acc;
        acc = '0;
        for (int k = int'(M) - 1; k >= 0; k--) begin
          acc = {acc[M-2:0], 1'b0} ^ (acc[M-1] ? POLY[M-1:0] : '0);
          if (b[k]) acc = acc ^ a;
        end
        p = acc;
      end
    end else begin : g_full_product
      localparam int PW = 2 * int'(M) - 1;
      // Full carry-less product, then one reduction pass from the top
      always_comb begin
        logic [PW-1:0] full;
        full = '0;
        for (int k = 0; k < int'(M); k++)
          if (b[k]) full = full ^ (PW'(a) << k);
        for (int k = PW - 1; k >= int'(M); k--)
          if (full[k]) full = full ^ (PW'(POLY) << (k - int'(M)));
        p = full[M-1:0];
      end
    end
  endgenerate

endmodule

// File: rtl/ibm_ctrl.sv
module ibm_ctrl
  import locator_pkg::*;
#(
  parameter int unsigned TMAX = 3,
  parameter int unsigned TW   = 2,
  parameter int unsigned LW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [TW-1:0] in_t,
  input  logic          syn_nz,
  input  logic          out_ready,
  output logic          in_ready,
  output logic          out_valid,
  output logic          accept,
  output logic          running,
  output logic [TW-1:0] t_eff,
  output logic [TW-1:0] t_run,
  output op_kind_t      op,
  output logic [TW-1:0] idx,
  output logic [LW-1:0] iter
);

  ctl_state_t    state;
  logic [LW-1:0] last_iter;

  always_comb begin
    if (in_t == '0)                t_eff = TW'(1);
    else if (in_t > TW'(TMAX))     t_eff = TW'(TMAX);
    else                           t_eff = in_t;
  end

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_DONE);
  assign running   = (state == ST_RUN);
  assign accept    = in_valid && in_ready;
  assign last_iter = LW'(2 * int'(t_run) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      t_run <= TW'(1);
      op    <= OP_DISC;
      idx   <= '0;
      iter  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          t_run <= t_eff;
          op    <= OP_DISC;
          idx   <= '0;
          iter  <= '0;
          state <= syn_nz ? ST_RUN : ST_DONE;
        end
        ST_RUN: begin
          unique case (op)
            OP_DISC: begin
              if (idx == t_run) op <= OP_SCALE;
              else              idx <= idx + TW'(1);
            end
            OP_SCALE: op <= OP_MERGE;
            default: begin
              if (idx == '0) begin
                if (iter == last_iter) state <= ST_DONE;
                else begin
                  iter <= iter + LW'(1);
                  op   <= OP_DISC;
                end
              end else begin
                idx <= idx - TW'(1);
                op  <= OP_SCALE;
              end
            end
          endcase
        end
        default: if (out_ready) state <= ST_IDLE;
      endcase
    end
  end

  // Independent count of run cycles for the latency check
  int lat_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lat_cnt <= 0;
    else if (accept)  lat_cnt <= 0;
    else if (running) lat_cnt <= lat_cnt + 1;
  end

  AST_RUN_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) && $past(running) |-> lat_cnt == 6 * int'(t_run) * (int'(t_run) + 1)); // R6
  AST_ZERO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !syn_nz |=> out_valid && !running); // R6
  AST_ACCEPT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready); // R1
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid); // R2

endmodule

// File: rtl/ibm_core.sv
module ibm_core
  import locator_pkg::*;
#(
  parameter int unsigned M    = 4,
  parameter int unsigned TMAX = 3,
  parameter int unsigned TW   = 2,
  parameter int unsigned LW   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     accept,
  input  logic [2*TMAX*M-1:0]      in_syn,
  input  logic [TW-1:0]            t_eff,
  input  logic [TW-1:0]            t_run,
  input  logic                     running,
  input  logic                     done,
  input  op_kind_t                 op,
  input  logic [TW-1:0]            idx,
  input  logic [LW-1:0]            iter,
  input  logic [M-1:0]             mul_p,
  output logic                     syn_nz,
  output logic [M-1:0]             mul_a,
  output logic [M-1:0]             mul_b,
  output logic [(TMAX+1)*M-1:0]    out_lambda,
  output logic [LW-1:0]            out_degree,
  output logic                     out_uncorrectable
);

  localparam int NSYN  = 2 * int'(TMAX);
  localparam int NCOEF = int'(TMAX) + 1;

  logic [M-1:0]  syn_q [NSYN];
  logic [M-1:0]  lam   [NCOEF];
  logic [M-1:0]  bp    [NCOEF];
  logic [M-1:0]  gamma, delta, acc;
  logic [LW-1:0] deg_l;
  logic [M-1:0]  prev_b, syn_sel;
  logic          swap;

  // Zero test over the syndromes the request actually uses
  always_comb begin
    syn_nz = 1'b0;
    for (int j = 0; j < NSYN; j++)
      if (j < 2 * int'(t_eff) && in_syn[j*M +: M] != '0) syn_nz = 1'b1;
  end

  always_comb begin
    prev_b  = (idx == '0) ? '0 : bp[idx - TW'(1)];
    syn_sel = (LW'(idx) > iter) ? '0 : syn_q[iter - LW'(idx)];
    swap    = (delta != '0) && ({deg_l, 1'b0} <= {1'b0, iter});
  end

  always_comb begin
    unique case (op)
      OP_DISC:  begin mul_a = lam[idx]; mul_b = syn_sel;  end
      OP_SCALE: begin mul_a = gamma;    mul_b = lam[idx]; end
      default:  begin mul_a = delta;    mul_b = prev_b;   end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < NSYN; j++)  syn_q[j] <= '0;
      for (int i = 0; i < NCOEF; i++) begin
        lam[i] <= (i == 0) ? M'(1) : '0;
        bp[i]  <= (i == 0) ? M'(1) : '0;
      end
      gamma <= M'(1);
      delta <= '0;
      acc   <= '0;
      deg_l <= '0;
    end else if (accept) begin
      for (int j = 0; j < NSYN; j++)  syn_q[j] <= in_syn[j*M +: M];
      for (int i = 0; i < NCOEF; i++) begin
        lam[i] <= (i == 0) ? M'(1) : '0;
        bp[i]  <= (i == 0) ? M'(1) : '0;
      end
      gamma <= M'(1);
      delta <= '0;
      deg_l <= '0;
    end else if (running) begin
      unique case (op)
        OP_DISC:  delta <= (idx == '0) ? mul_p : (delta ^ mul_p);
        OP_SCALE: acc <= mul_p;
        default: begin
          lam[idx] <= acc ^ mul_p;
          bp[idx]  <= swap ? lam[idx] : prev_b;
          if (idx == '0 && swap) begin
            deg_l <= iter + LW'(1) - deg_l;
            gamma <= delta;
          end
        end
      endcase
    end
  end

  always_comb begin
    for (int i = 0; i < NCOEF; i++) out_lambda[i*M +: M] = lam[i];
  end
  assign out_degree        = deg_l;
  assign out_uncorrectable = deg_l > LW'(t_run);

  // Checker signals for the polynomial shape
  logic above_deg_clear, above_t_clear;
  always_comb begin
    above_deg_clear = 1'b1;
    above_t_clear   = 1'b1;
    for (int i = 0; i < NCOEF; i++) begin
      if (i > int'(deg_l) && lam[i] != '0) above_deg_clear = 1'b0;
      if (i > int'(t_run) && lam[i] != '0) above_t_clear   = 1'b0;
    end
  end

  AST_GAMMA_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> gamma != '0); // R10
  AST_LAMBDA0_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> lam[0] != '0); // R10
  AST_DEGREE_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    done && !out_uncorrectable |-> above_deg_clear); // R10
  AST_ABOVE_T_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> above_t_clear); // R7
  AST_DEGREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> deg_l <= LW'(2 * int'(t_run))); // R4

endmodule

// File: rtl/locator_ibm_serial.sv
module locator_ibm_serial
  import locator_pkg::*;
#(
  parameter int unsigned M        = 4,
  parameter int unsigned TMAX     = 3,
  parameter logic [M:0]  POLY     = 5'h13,
  parameter int unsigned MUL_ARCH = 0,
  localparam int unsigned TW      = $clog2(TMAX + 1),
  localparam int unsigned LW      = $clog2(2 * TMAX + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [TW-1:0]          in_t,
  input  logic [2*TMAX*M-1:0]    in_syn,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [(TMAX+1)*M-1:0]  out_lambda,
  output logic [LW-1:0]          out_degree,
  output logic                   out_uncorrectable
);

  logic          accept, running, syn_nz;
  logic [TW-1:0] t_eff, t_run, idx;
  logic [LW-1:0] iter;
  op_kind_t      op;
  logic [M-1:0]  mul_a, mul_b, mul_p;

  ibm_ctrl #(.TMAX(TMAX), .TW(TW), .LW(LW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_t(in_t),
    .syn_nz(syn_nz), .out_ready(out_ready), .in_ready(in_ready),
    .out_valid(out_valid), .accept(accept), .running(running),
    .t_eff(t_eff), .t_run(t_run), .op(op), .idx(idx), .iter(iter)
  );

  ibm_core #(.M(M), .TMAX(TMAX), .TW(TW), .LW(LW)) u_core (
    .clk(clk), .rst_n(rst_n), .accept(accept), .in_syn(in_syn),
    .t_eff(t_eff), .t_run(t_run), .running(running), .done(out_valid),
    .op(op), .idx(idx), .iter(iter), .mul_p(mul_p), .syn_nz(syn_nz),
    .mul_a(mul_a), .mul_b(mul_b), .out_lambda(out_lambda),
    .out_degree(out_degree), .out_uncorrectable(out_uncorrectable)
  );

  gf_mul #(.M(M), .POLY(POLY), .ARCH(MUL_ARCH)) u_mul (
    .a(mul_a), .b(mul_b), .p(mul_p)
  );

  AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_lambda) && $stable(out_degree)
                                && $stable(out_uncorrectable)); // R2

endmodule

// File: tb/locator_ibm_serial_bench.sv
module locator_ibm_serial_bench;

  localparam int M = 4;
  localparam int TMAX = 3;
  localparam int NCASE = 12;
  localparam int unsigned CASE_T [NCASE] = '{1, 1, 1, 1, 2, 2, 2, 3, 3, 3, 0, 3};
  localparam logic [14:0] CASE_ERR [NCASE] = '{
    15'h0000, 15'h0001, 15'h4000, 15'h0204, 15'h0082, 15'h0821,
    15'h0008, 15'h0007, 15'h5110, 15'h2040, 15'h0020, 15'h0400};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        out_ready = 1'b0;
  logic [1:0]  in_t = 2'd1;
  logic [23:0] in_syn = '0;
  logic        in_ready, out_valid, out_unc;
  logic [15:0] out_lambda;
  logic [2:0]  out_degree;
  logic        in_ready_p, out_valid_p, out_unc_p;
  logic [15:0] out_lambda_p;
  logic [2:0]  out_degree_p;

  int checks = 0;
  int fails = 0;
  int mism = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  locator_ibm_serial #(.M(M), .TMAX(TMAX), .POLY(5'h13), .MUL_ARCH(0)) u_locator_ibm_serial (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_t(in_t), .in_syn(in_syn), .out_valid(out_valid), .out_ready(out_ready),
    .out_lambda(out_lambda), .out_degree(out_degree), .out_uncorrectable(out_unc));

  locator_ibm_serial #(.M(M), .TMAX(TMAX), .POLY(5'h13), .MUL_ARCH(1)) u_locator_ibm_serial_par (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_p),
    .in_t(in_t), .in_syn(in_syn), .out_valid(out_valid_p), .out_ready(out_ready),
    .out_lambda(out_lambda_p), .out_degree(out_degree_p), .out_uncorrectable(out_unc_p));

  // R8: both multiplier builds must agree on every cycle
  always @(negedge clk)
    if (rst_n && {in_ready, out_valid, out_lambda, out_degree, out_unc} !=
        {in_ready_p, out_valid_p, out_lambda_p, out_degree_p, out_unc_p}) mism++;

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      report();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // GF(16), x^4+x+1, LSB-first multiply
  function automatic logic [3:0] gmul(input logic [3:0] a, input logic [3:0] b);
    logic [3:0] r = '0;
    logic [3:0] aa = a;
    for (int k = 0; k < 4; k++) begin
      if (b[k]) r ^= aa;
      aa = {aa[2:0], 1'b0} ^ (aa[3] ? 4'h3 : 4'h0);
    end
    return r;
  endfunction

  function automatic logic [3:0] apow(input int e);
    logic [3:0] r = 4'h1;
    for (int k = 0; k < e % 15; k++) r = gmul(r, 4'h2);
    return r;
  endfunction

  function automatic logic [23:0] syn_of(input logic [14:0] err);
    logic [23:0] s = '0;
    for (int j = 1; j <= 6; j++)
      for (int p = 0; p < 15; p++)
        if (err[p]) s[(j-1)*4 +: 4] ^= apow(j * p);
    return s;
  endfunction

  function automatic void model(input int t, input logic [23:0] syn,
                                output logic [15:0] lam_o, output int deg_o);
    logic [3:0] lam [4];
    logic [3:0] bb [4];
    logic [3:0] nl [4];
    logic [3:0] g, d;
    int L = 0;
    for (int i = 0; i < 4; i++) begin
      lam[i] = (i == 0) ? 4'h1 : 4'h0;
      bb[i] = lam[i];
    end
    g = 4'h1;
    for (int r = 0; r < 2 * t; r++) begin
      d = '0;
      for (int i = 0; i <= t; i++)
        if (i <= r) d ^= gmul(lam[i], syn[(r-i)*4 +: 4]);
      for (int i = 0; i <= t; i++)
        nl[i] = gmul(g, lam[i]) ^ ((i > 0) ? gmul(d, bb[i-1]) : 4'h0);
      if (d != 0 && 2 * L <= r) begin
        for (int i = 0; i <= t; i++) bb[i] = lam[i];
        L = r + 1 - L;
        g = d;
      end else begin
        for (int i = t; i >= 1; i--) bb[i] = bb[i-1];
        bb[0] = '0;
      end
      for (int i = 0; i <= t; i++) lam[i] = nl[i];
    end
    for (int i = 0; i < 4; i++) lam_o[i*4 +: 4] = lam[i];
    deg_o = L;
  endfunction

  task automatic run_case(input int t_in, input logic [23:0] syn,
                          input logic [14:0] err, input bit hold);
    int te, exp_deg, lat, exp_lat, w;
    logic [15:0] exp_lam, held;
    bit zero;
    te = (t_in == 0) ? 1 : ((t_in > TMAX) ? TMAX : t_in);
    model(te, syn, exp_lam, exp_deg);
    zero = 1'b1;
    for (int j = 0; j < 2 * te; j++) if (syn[j*4 +: 4] != 0) zero = 1'b0;
    exp_lat = zero ? 0 : 6 * te * (te + 1);
    if (zero) begin exp_lam = 16'h0001; exp_deg = 0; end
    w = $countones(err);

    @(negedge clk);
    in_t = 2'(t_in); in_syn = syn; in_valid = 1'b1;
    chk(in_ready == 1'b1, "R1", "in_ready before request", in_ready, 1);
    @(posedge clk); #1;
    in_valid = 1'b0; in_syn = ~syn;   // R1: changes after acceptance must not matter
    lat = 0;
    @(negedge clk);
    if (!out_valid) chk(in_ready == 1'b0, "R1", "in_ready while busy", in_ready, 0);
    while (!out_valid && lat < 1000) begin lat++; @(negedge clk); end
    chk(lat == exp_lat, "R6", "latency", lat, exp_lat);
    if (hold) begin
      held = out_lambda;
      repeat (3) @(negedge clk);
      chk(out_valid && out_lambda == held, "R2", "held result", out_lambda, held);
    end
    chk(out_lambda == exp_lam, "R3", "lambda", out_lambda, exp_lam);
    chk(int'(out_degree) == exp_deg, "R4", "degree", out_degree, exp_deg);
    chk(out_unc == (exp_deg > te), "R5", "uncorrectable", out_unc, exp_deg > te);
    if (w <= te) begin
      chk(int'(out_degree) == w, "R4", "degree equals weight", out_degree, w);
      for (int p = 0; p < 15; p++) if (err[p]) begin
        logic [3:0] v = '0;
        for (int i = 0; i < 4; i++) v ^= gmul(out_lambda[i*4 +: 4], apow(i * (15 - p)));
        chk(v == 0, "R3", "root at error location", v, 0);
      end
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(!out_valid && in_ready, "R2", "result consumed", {out_valid, in_ready}, 2'b01);
  endtask

  initial begin
    logic [23:0] s;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R9", "reset state",
        {in_ready, out_valid}, 2'b10);
    rst_n = 1'b1;

    for (int n = 0; n < NCASE; n++)
      run_case(int'(CASE_T[n]), syn_of(CASE_ERR[n]), CASE_ERR[n], (n % 4) == 1);

    // R7: syndromes above S_2t carry junk and must not matter
    s = syn_of(15'h0008); s[23:8] = 16'hBEEF;
    run_case(1, s, 15'h0008, 1'b0);
    s = '0; s[23:8] = 16'hC0DE;
    run_case(1, s, 15'h0000, 1'b0);

    // R3/R4/R5: random patterns of weight 0 to t+1
    for (int n = 0; n < 24; n++) begin
      int t = 1 + int'($urandom % 3);
      int w = int'($urandom % (t + 2));
      logic [14:0] e = '0;
      while ($countones(e) < w) e[$urandom % 15] = 1'b1;
      run_case(t, syn_of(e), e, 1'b0);
    end

    chk(mism == 0, "R8", "serial vs parallel multiplier mismatches", mism, 0);
    report();
    $finish;
  end

endmodule